// File: doc/BRIEF.md
# Reloading Local Timer with Routable Interrupt

This block is a periodic down-counter that advances on a reference tick. Software writes a control word carrying a reload value (up to 28 bits), a timer-enable bit and an interrupt-enable bit. The counter then repeats a fixed period of that many ticks. Each time the count runs out, a sticky flag is raised and the next period starts at once from the reload value, with no software action needed. A separate write-only acknowledge location clears the flag and can restart the current period from the beginning. These are two independent actions chosen by two bits of the written word.

A small routing register chooses which core receives the request and whether it goes out on that core's normal (IRQ) line or its fast (FIQ) line. While interrupt enable and the flag are both set, exactly one request output is high. All other request outputs stay low. The reference tick comes from outside the block and arrives as a one-cycle enable strobe on `tick_en`. Its nominal rate is 38.4 MHz, but any strobe pattern works. Registers are accessed through a simple 32-bit write strobe with a combinational read path.

Top module: `lrt_timer`

## Requirements
- R1: After reset, the control word (offset 0x34) and the route register (offset 0x24) read as zero, the timer is stopped and every request output is low.
- R2: A write to offset 0x34 stores all 32 bits, and a read of 0x34 returns them. The bit layout is: bit 31 flag, bit 30 reload request, bit 29 interrupt enable, bit 28 timer enable, bits [27:0] reload value.
- R3: After a control write with timer enable set and a nonzero reload value N, the flag becomes set at the Nth following cycle in which `tick_en` is high. Cycles with `tick_en` low do not count.
- R4: On expiry the count restarts from N in the same cycle, so the next expiry follows after another N ticks.
- R5: The flag stays set until a write to offset 0x38 with bit 31 set. An acknowledge write with bit 31 clear leaves the flag unchanged.
- R6: An acknowledge write with bit 30 set restarts the period from N when timer enable is set.
- R7: Offset 0x38 always reads as zero.
- R8: The route register keeps written bits [2:0]. Bits [1:0] select the core and bit 2 selects FIQ (1) or IRQ (0). Bits [31:3] read as zero.
- R9: `irq_req[c]` is high exactly when interrupt enable and the flag are set, route bit 2 is 0 and route bits [1:0] equal c. `fiq_req[c]` follows the same rule with route bit 2 equal to 1. At most one request output is high at a time.
- R10: With timer enable clear, ticks cause no expiry.
- R11: A control word with timer enable set and a reload value of zero is treated as stopped and never expires.
- R12: If an expiry and a flag-clearing acknowledge fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Reference tick strobe; the counter moves only when high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 4 | Per-core normal interrupt request |
| fiq_req | output | 4 | Per-core fast interrupt request |

## Verification
The assertions assume that each register access lasts a single cycle with a stable address, and that the flag changes only through a control write, an expiry or a clearing acknowledge. They also assume that, in the default configuration, the request outputs follow the state registers without delay. The stimulus mixes random control words with small reload values (zero included) and random acknowledge, route and unmapped writes, all with a random tick. This keeps expiries frequent, so collisions between acknowledges and expiries actually occur. A bench model updated on every edge predicts each request output and each readback.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

   localparam int DATA_W     = 32;
   localparam int FLAG_BIT   = 31;
   localparam int RELOAD_BIT = 30;
   localparam int IEN_BIT    = 29;
   localparam int TEN_BIT    = 28;
   localparam int MAX_VAL_W  = 28;

   localparam logic [7:0] ROUTE_OFS = 8'h24;
   localparam logic [7:0] CTRL_OFS  = 8'h34;
   localparam logic [7:0] ACK_OFS   = 8'h38;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_ROUTE = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_ACK   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/lrt_regs.sv
module lrt_regs
   import lrt_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int ROUTE_W = 3,
   parameter int VAL_W   = 28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 expire,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [DATA_W-1:0]    ctrl_q,
   output logic [ROUTE_W-1:0]   route_q,
   output logic                 cnt_load,
   output logic [VAL_W-1:0]     load_val
);

   localparam logic [DATA_W-1:0] VAL_MASK  = DATA_W'((64'd1 << VAL_W) - 64'd1);
   localparam logic [DATA_W-1:0] CTRL_MASK = 32'hF000_0000 | VAL_MASK;

   reg_sel_e sel;
   logic     ctrl_wr;
   logic     ack_wr;
   logic     route_wr;
   logic     restart;

   always_comb begin
      if (bus_addr == ADDR_W'(CTRL_OFS))       sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(ACK_OFS))   sel = SEL_ACK;
      else if (bus_addr == ADDR_W'(ROUTE_OFS)) sel = SEL_ROUTE;
      else                                     sel = SEL_NONE;
   end

   assign ctrl_wr  = bus_wr && (sel == SEL_CTRL);
   assign ack_wr   = bus_wr && (sel == SEL_ACK);
   assign route_wr = bus_wr && (sel == SEL_ROUTE);
   assign restart  = ack_wr && bus_wdata[RELOAD_BIT] && ctrl_q[TEN_BIT];

   assign cnt_load = ctrl_wr || restart;
   assign load_val = ctrl_wr ? bus_wdata[VAL_W-1:0] : ctrl_q[VAL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= bus_wdata & CTRL_MASK;
      end else if (expire) begin
         ctrl_q[FLAG_BIT] <= 1'b1;
      end else if (ack_wr && bus_wdata[FLAG_BIT]) begin
         ctrl_q[FLAG_BIT] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        route_q <= '0;
      else if (route_wr) route_q <= bus_wdata[ROUTE_W-1:0];
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:  bus_rdata = ctrl_q;
         SEL_ROUTE: bus_rdata = DATA_W'(route_q);
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/lrt_counter.sv
module lrt_counter #(
   parameter int VAL_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             load,
   input  logic [VAL_W-1:0] load_val,
   output logic             expire
);

   logic [VAL_W-1:0] cnt_q;
   logic             at_last;
   logic             step;

   assign at_last = (cnt_q == VAL_W'(1));
   assign step    = run && tick_en && !load;
   assign expire  = step && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= load_val;
      else if (expire)  cnt_q <= load_val;
      else if (step)    cnt_q <= cnt_q - VAL_W'(1);
   end

endmodule

// File: rtl/lrt_router.sv
module lrt_router #(
   parameter int NUM_CORES = 4,
   parameter int CORE_W    = 2,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic [CORE_W:0]      route,
   output logic [NUM_CORES-1:0] irq_req,
   output logic [NUM_CORES-1:0] fiq_req
);

   logic [NUM_CORES-1:0] irq_nxt;
   logic [NUM_CORES-1:0] fiq_nxt;
   logic                 use_fiq;

   assign use_fiq = route[CORE_W];

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic hit;
      assign hit        = active && (route[CORE_W-1:0] == CORE_W'(c));
      assign irq_nxt[c] = hit && !use_fiq;
      assign fiq_nxt[c] = hit && use_fiq;
   end

   if (OUT_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_req <= '0;
            fiq_req <= '0;
         end else begin
            irq_req <= irq_nxt;
            fiq_req <= fiq_nxt;
         end
      end
   end else begin : g_comb
      assign irq_req = irq_nxt;
      assign fiq_req = fiq_nxt;
   end

endmodule

// File: rtl/lrt_timer.sv
module lrt_timer
   import lrt_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int VAL_W     = 28,
   parameter int ADDR_W    = 8,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CORES-1:0] irq_req,
   output logic [NUM_CORES-1:0] fiq_req
);

   localparam int CORE_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int ROUTE_W = CORE_W + 1;

   if (NUM_CORES < 2 || (1 << CORE_W) != NUM_CORES) begin : g_bad_cores
      $error("lrt_timer: NUM_CORES must be a power of two, at least 2");
   end
   if (VAL_W < 2 || VAL_W > MAX_VAL_W) begin : g_bad_val
      $error("lrt_timer: VAL_W must lie in 2..28");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lrt_timer: ADDR_W must be at least 8");
   end
   if (ROUTE_W > TEN_BIT) begin : g_bad_route
      $error("lrt_timer: route field too wide");
   end

   logic [31:0]        ctrl_q;
   logic [ROUTE_W-1:0] route_q;
   logic               cnt_load;
   logic [VAL_W-1:0]   load_val;
   logic               expire;
   logic               run;
   logic               active;

   assign run    = ctrl_q[TEN_BIT] && (ctrl_q[VAL_W-1:0] != '0);
   assign active = ctrl_q[IEN_BIT] && ctrl_q[FLAG_BIT];

   lrt_regs #(
      .ADDR_W  (ADDR_W),
      .ROUTE_W (ROUTE_W),
      .VAL_W   (VAL_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .expire    (expire),
      .bus_rdata (bus_rdata),
      .ctrl_q    (ctrl_q),
      .route_q   (route_q),
      .cnt_load  (cnt_load),
      .load_val  (load_val)
   );

   lrt_counter #(
      .VAL_W (VAL_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .run      (run),
      .load     (cnt_load),
      .load_val (load_val),
      .expire   (expire)
   );

   lrt_router #(
      .NUM_CORES (NUM_CORES),
      .CORE_W    (CORE_W),
      .OUT_REG   (OUT_REG)
   ) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .route   (route_q),
      .irq_req (irq_req),
      .fiq_req (fiq_req)
   );

endmodule

// File: rtl/lrt_checker.sv
module lrt_checker
   import lrt_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8,
   parameter int ROUTE_W   = 3,
   parameter bit OUT_REG   = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [31:0]          bus_wdata,
   input logic [31:0]          bus_rdata,
   input logic [NUM_CORES-1:0] irq_req,
   input logic [NUM_CORES-1:0] fiq_req,
   input logic                 flag,
   input logic                 int_en,
   input logic                 tmr_en
);

   logic ctrl_hit;
   logic clr_hit;

   assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
   assign clr_hit  = bus_wr && (bus_addr == ADDR_W'(ACK_OFS)) && bus_wdata[FLAG_BIT];

   // R9: never more than one request line high
   p_one_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_req, fiq_req}));

   // R5: flag holds unless cleared by acknowledge or overwritten
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ctrl_hit && !clr_hit) |=> flag);

   // R10: a stopped timer cannot raise the flag by itself
   p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !flag && !ctrl_hit) |=> !flag);

   // R7: acknowledge location reads zero
   p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ACK_OFS)) |-> (bus_rdata == 32'd0));

   // R8: upper route bits read zero
   p_route_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(ROUTE_OFS)) |-> (bus_rdata[31:ROUTE_W] == '0));

   if (!OUT_REG) begin : g_direct
      // R9: a request needs both interrupt enable and the flag
      p_req_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (|{irq_req, fiq_req}) |-> (int_en && flag));
      // R9: flag with enable always drives some line
      p_flag_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (int_en && flag) |-> (|{irq_req, fiq_req}));
   end

endmodule

bind lrt_timer lrt_checker #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .ROUTE_W   (ROUTE_W),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_req   (irq_req),
   .fiq_req   (fiq_req),
   .flag      (ctrl_q[31]),
   .int_en    (ctrl_q[29]),
   .tmr_en    (ctrl_q[28])
);

// File: tb/lrt_timer_test.sv
module lrt_timer_test;

   localparam logic [7:0] A_ROUTE = 8'h24;
   localparam logic [7:0] A_CTRL  = 8'h34;
   localparam logic [7:0] A_ACK   = 8'h38;
   localparam logic [7:0] A_NONE  = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_req;
   logic [3:0]  fiq_req;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] m_ctrl  = '0;
   logic [2:0]  m_route = '0;
   logic [27:0] m_cnt   = '0;

   always #10 clk = ~clk;

   lrt_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_req   (irq_req),
      .fiq_req   (fiq_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_lines(input logic [31:0] c, input logic [2:0] r);
      logic [7:0] v;
      v = '0;
      if (c[29] && c[31]) begin
         if (r[2]) v[4 + r[1:0]] = 1'b1;
         else      v[r[1:0]]     = 1'b1;
      end
      return v;
   endfunction

   task automatic model(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
      logic run, restart, clr, ex;
      run = m_ctrl[28] && (m_ctrl[27:0] != 0);
      if (w && a == A_CTRL) begin
         m_ctrl = d;
         m_cnt  = d[27:0];
      end else begin
         restart = w && a == A_ACK && d[30] && m_ctrl[28];
         clr     = w && a == A_ACK && d[31];
         ex      = 1'b0;
         if (restart) m_cnt = m_ctrl[27:0];
         else if (run && t) begin
            if (m_cnt == 28'd1) begin ex = 1'b1; m_cnt = m_ctrl[27:0]; end
            else m_cnt = m_cnt - 28'd1;
         end
         if (ex)       m_ctrl[31] = 1'b1;
         else if (clr) m_ctrl[31] = 1'b0;
      end
      if (w && a == A_ROUTE) m_route = d[2:0];
   endtask

   // drive one cycle; compare request lines against the model afterwards (R9)
   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
      logic [7:0] e;
      bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t;
      @(posedge clk);
      model(w, a, d, t);
      @(negedge clk);
      bus_wr = 1'b0; tick_en = 1'b0;
      e = exp_lines(m_ctrl, m_route);
      chk({fiq_req, irq_req} == e, "R9 model lines", {24'd0, fiq_req, irq_req}, {24'd0, e});
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b0, A_NONE, 32'd0, 1'b1);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, 32'd0, "R1 ctrl after reset");
      rd(A_ROUTE, 32'd0, "R1 route after reset");
      chk({fiq_req, irq_req} == 8'd0, "R1 lines after reset", {24'd0, fiq_req, irq_req}, 32'd0);

      // R8 route keeps low three bits: core 1, FIQ
      step(1'b1, A_ROUTE, 32'hFFFF_FFFD, 1'b0);
      rd(A_ROUTE, 32'd5, "R8 route readback");

      // R2 control stores whole word
      step(1'b1, A_CTRL, 32'h4ABC_DEF1, 1'b0);
      rd(A_CTRL, 32'h4ABC_DEF1, "R2 ctrl readback");

      // R3 expiry after N ticks, idle cycles ignored
      step(1'b1, A_CTRL, 32'h3000_0005, 1'b0);
      ticks(2);
      step(1'b0, A_NONE, 32'd0, 1'b0);
      ticks(2);
      chk(fiq_req == 4'b0000, "R3 not before N ticks", {28'd0, fiq_req}, 32'd0);
      ticks(1);
      chk(fiq_req == 4'b0010, "R3 expiry at N ticks", {28'd0, fiq_req}, 32'd2);
      rd(A_CTRL, 32'hB000_0005, "R3 flag visible");

      // R5 flag sticky, R4 periodic restart
      ticks(2);
      chk(fiq_req == 4'b0010, "R5 flag held", {28'd0, fiq_req}, 32'd2);
      step(1'b1, A_ACK, 32'h8000_0000, 1'b0);
      chk(fiq_req == 4'b0000, "R5 flag cleared", {28'd0, fiq_req}, 32'd0);
      ticks(2);
      chk(fiq_req == 4'b0000, "R4 before reload period", {28'd0, fiq_req}, 32'd0);
      ticks(1);
      chk(fiq_req == 4'b0010, "R4 periodic expiry", {28'd0, fiq_req}, 32'd2);
      step(1'b1, A_ACK, 32'h0000_0001, 1'b0);
      chk(fiq_req == 4'b0010, "R5 ack without bit31", {28'd0, fiq_req}, 32'd2);
      rd(A_ACK, 32'd0, "R7 ack reads zero");

      // R6 restart by acknowledge
      ticks(3);
      step(1'b1, A_ACK, 32'hC000_0000, 1'b0);
      ticks(4);
      chk(fiq_req == 4'b0000, "R6 restarted period", {28'd0, fiq_req}, 32'd0);
      ticks(1);
      chk(fiq_req == 4'b0010, "R6 expiry after restart", {28'd0, fiq_req}, 32'd2);

      // R12 expiry and clear in the same cycle
      step(1'b1, A_ACK, 32'h8000_0000, 1'b0);
      ticks(4);
      step(1'b1, A_ACK, 32'h8000_0000, 1'b1);
      chk(fiq_req == 4'b0010, "R12 expiry beats clear", {28'd0, fiq_req}, 32'd2);

      // R9 no request without interrupt enable, then IRQ routing
      step(1'b1, A_CTRL, 32'h1000_0003, 1'b0);
      ticks(3);
      chk({fiq_req, irq_req} == 8'd0, "R9 masked by enable", {24'd0, fiq_req, irq_req}, 32'd0);
      rd(A_CTRL, 32'h9000_0003, "R9 flag set while masked");
      step(1'b1, A_ROUTE, 32'd2, 1'b0);
      step(1'b1, A_CTRL, 32'h3000_0001, 1'b0);
      ticks(1);
      chk(irq_req == 4'b0100 && fiq_req == 4'b0000, "R9 irq to core 2", {24'd0, fiq_req, irq_req}, 32'h04);

      // R10 disabled timer never expires
      step(1'b1, A_CTRL, 32'h2000_0002, 1'b0);
      ticks(6);
      rd(A_CTRL, 32'h2000_0002, "R10 no expiry when disabled");
      chk(irq_req == 4'b0000, "R10 lines low", {28'd0, irq_req}, 32'd0);

      // R11 zero reload treated as stopped
      step(1'b1, A_CTRL, 32'h3000_0000, 1'b0);
      ticks(6);
      rd(A_CTRL, 32'h3000_0000, "R11 zero reload no expiry");

      // random mix checked against the model every cycle
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         int op;
         op = int'($urandom % 8);
         d  = $urandom;
         case (op)
            0, 1: step(1'b1, A_CTRL, {d[31:28], 24'd0, 4'($urandom % 6)}, d[5]);
            2, 3: step(1'b1, A_ACK, d, d[7]);
            4:    step(1'b1, A_ROUTE, d, d[3]);
            5:    step(1'b1, A_NONE, d, d[1]);
            default: step(1'b0, A_NONE, 32'd0, d[2]);
         endcase
         if (i % 50 == 0) rd(A_CTRL, m_ctrl, "R2 random ctrl readback");
         if (i % 70 == 0) rd(A_ROUTE, {29'd0, m_route}, "R8 random route readback");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule